// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a down-counting interval timer controlled through a small register file. Software writes a reload value and a control word; the timer copies the reload value into its counter when it is switched on and then steps the counter down by one on every count event. A count event is either every clock cycle or a cycle in which the external prescale strobe is high, chosen by a parameter. That strobe is typically driven by another timer's interrupt or by an outside enable.

When the counter is at zero and a count event arrives, the timer lapses and raises a one-cycle interrupt pulse. In repeating mode the following count event reloads the counter, which makes the spacing between interrupts the reload value plus two count events. In single-shot mode the timer halts at zero after its one lapse and stays there until it is switched off and back on. Switching the timer off freezes the counter where it stands. The counter can be read back at any moment.

Top module: `pit_prescaled_timer`

## Requirements
- R1: After reset the reload value, the counter and the control word all read zero and the interrupt output is low.
- R2: A control write that sets the enable bit (bit 0) while the timer is off loads the reload value into the counter, readable in the cycle after the write.
- R3: While on and not lapsed, each count event lowers the counter by exactly one; a cycle with no count event (prescale strobe low) leaves it unchanged.
- R4: In repeating mode (control bit 1 set) the first interrupt follows the count event numbered reload+1 after enabling, and later interrupts are exactly reload+2 count events apart.
- R5: In single-shot mode (control bit 1 clear) exactly one interrupt occurs, at count event reload+1; after it the counter stays at zero and no further interrupt comes.
- R6: While the enable bit is clear the counter holds its value and no interrupt is raised, whatever the prescale strobe does.
- R7: The interrupt output is never high for two cycles in a row.
- R8: Reads are combinational by offset: 0 returns the reload value, 1 the counter, 2 the control word in bits 1:0, 3 returns zero; bits above the counter width (and above bit 1 for the control word) read zero.
- R9: A reload value written while the timer runs does not disturb the counter; it is used at the next reload.
- R10: A control write that keeps the enable bit set while the timer is already on does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register offset for the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Register offset for the read |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| tick_in | input | 1 | Prescale strobe; one count event per high cycle |
| irq | output | 1 | One-cycle interrupt pulse on each lapse |

## Verification
The checks take for granted that the prescale strobe is a plain level sampled each cycle and that a new reload value is never written in the same cycle as a reload event. The bench keeps the strobe low during every register write so that each write's effect is observed apart from counting, and it draws reload values and strobe densities at random within small ranges so that many lapses fit in the run. Interrupt spacing is measured in count events, not cycles, which makes the expected period independent of the random strobe pattern.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int REG_AW = 2;

    // register offsets; the read mux and the write decoder share these
    localparam logic [REG_AW-1:0] OFS_RELOAD = 2'd0;
    localparam logic [REG_AW-1:0] OFS_COUNT  = 2'd1;
    localparam logic [REG_AW-1:0] OFS_CTRL   = 2'd2;

    // control word bit positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_REPT_BIT = 1;

endpackage

// File: rtl/pit_tick_sel.sv
module pit_tick_sel #(
    parameter bit USE_PRESCALE = 1'b1
) (
    input  logic tick_in,
    output logic tick
);

    generate
        if (USE_PRESCALE) begin : g_strobe
            assign tick = tick_in;
        end else begin : g_every_clk
            logic unused_tick_in;
            assign unused_tick_in = tick_in;
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/pit_ctrl_regs.sv
module pit_ctrl_regs
    import pit_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic [CNT_W-1:0]  reload_val,
    output logic              run,
    output logic              repeat_mode,
    output logic              load
);

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic             en;
        logic             rept;
    } regs_t;

    regs_t r_d, r_q;

    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DATA_W-1:CNT_W];

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                OFS_RELOAD: r_d.reload = wr_data[CNT_W-1:0];
                OFS_CTRL: begin
                    r_d.en   = wr_data[CTRL_EN_BIT];
                    r_d.rept = wr_data[CTRL_REPT_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // the counter acts on the control word being written this cycle
    assign run         = r_d.en;
    assign repeat_mode = r_d.rept;
    assign load        = r_d.en && !r_q.en;
    assign reload_val  = r_q.reload;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFS_RELOAD: rd_data[CNT_W-1:0] = r_q.reload;
            OFS_COUNT:  rd_data[CNT_W-1:0] = cnt_val;
            OFS_CTRL: begin
                rd_data[CTRL_EN_BIT]   = r_q.en;
                rd_data[CTRL_REPT_BIT] = r_q.rept;
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pit_down_core.sv
module pit_down_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             repeat_mode,
    input  logic             load,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             pend_q,
    output logic             done_q,
    output logic             irq_q
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic             done;
        logic             irq;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.irq = 1'b0;
        if (load) begin
            c_d.cnt  = reload_val;
            c_d.pend = 1'b0;
            c_d.done = 1'b0;
        end else if (run && tick && !c_q.done) begin
            if (c_q.pend) begin
                c_d.cnt  = reload_val;
                c_d.pend = 1'b0;
            end else if (c_q.cnt == '0) begin
                c_d.irq = 1'b1;
                if (repeat_mode) begin
                    c_d.pend = 1'b1;
                end else begin
                    c_d.done = 1'b1;
                end
            end else begin
                c_d.cnt = c_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_q  = c_q.cnt;
    assign pend_q = c_q.pend;
    assign done_q = c_q.done;
    assign irq_q  = c_q.irq;

endmodule

// File: rtl/pit_prescaled_timer.sv
module pit_prescaled_timer
    import pit_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int DATA_W       = 32,
    parameter bit USE_PRESCALE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick_in,
    output logic              irq
);

    logic             tick_w;
    logic             run_w;
    logic             rept_w;
    logic             load_w;
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] cnt_w;
    logic             pend_w;
    logic             done_w;

    pit_tick_sel #(
        .USE_PRESCALE(USE_PRESCALE)
    ) i_tick_sel (
        .tick_in(tick_in),
        .tick   (tick_w)
    );

    pit_ctrl_regs #(
        .CNT_W (CNT_W),
        .DATA_W(DATA_W)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .cnt_val    (cnt_w),
        .reload_val (reload_w),
        .run        (run_w),
        .repeat_mode(rept_w),
        .load       (load_w)
    );

    pit_down_core #(
        .CNT_W(CNT_W)
    ) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .run        (run_w),
        .repeat_mode(rept_w),
        .load       (load_w),
        .reload_val (reload_w),
        .cnt_q      (cnt_w),
        .pend_q     (pend_w),
        .done_q     (done_w),
        .irq_q      (irq)
    );

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             tick,
    input logic             load,
    input logic [CNT_W-1:0] cnt,
    input logic             pend,
    input logic             done,
    input logic             irq
);

    // R7
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(cnt) && !irq));

    // R3
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && !done && !pend && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R3
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> ($stable(cnt) && !irq));

    // R5
    halted_stays_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> (!irq && cnt == '0));

    // R4
    lapse_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == '0 && (pend || done)));

endmodule

bind pit_prescaled_timer pit_timer_chk #(
    .CNT_W(CNT_W)
) i_chk (
    .clk (clk),
    .rst_n(rst_n),
    .run (run_w),
    .tick(tick_w),
    .load(load_w),
    .cnt (cnt_w),
    .pend(pend_w),
    .done(done_w),
    .irq (irq)
);

// File: tb/test_pit_prescaled_timer.sv
module test_pit_prescaled_timer;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [1:0]        wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [1:0]        rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              tick_in;
    logic              irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pit_prescaled_timer #(
        .CNT_W       (CNT_W),
        .DATA_W      (DATA_W),
        .USE_PRESCALE(1'b1)
    ) i_pit_prescaled_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .tick_in(tick_in),
        .irq    (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one clock with the given strobe; returns at the following falling edge
    task automatic cyc(input logic t);
        tick_in = t;
        @(negedge clk);
        tick_in = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick_in = 1'b0;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [31:0] rd(input logic [1:0] a);
        rd_addr = a;
        return rd_data;
    endfunction

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    function automatic logic [31:0] first_gap(input int p);
        return p + 1;
    endfunction

    function automatic logic [31:0] period(input int p);
        return p + 2;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; tick_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 reload", 2'd0, 32'h0);
        rd_chk("R1 counter", 2'd1, 32'h0);
        rd_chk("R1 control", 2'd2, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R8 widths and the empty offset
        wr(2'd0, 32'h1234_5678);
        rd_chk("R8 reload truncated", 2'd0, 32'h0000_5678);
        rd_chk("R8 offset 3", 2'd3, 32'h0);
        wr(2'd2, 32'hFFFF_FFF2);
        rd_chk("R8 control bits", 2'd2, 32'h2);
        rd_chk("R6 counter held off", 2'd1, 32'h0);
        wr(2'd2, 32'h0);

        // R5 single shot, reload 5
        wr(2'd0, 32'd5);
        wr(2'd2, 32'h1);
        rd_chk("R2 load on enable", 2'd1, 32'd5);
        for (int i = 0; i < 4; i++) cyc(1'b0);
        rd_chk("R3 hold without tick", 2'd1, 32'd5);
        for (int i = 0; i < 3; i++) cyc(1'b1);
        rd_chk("R3 three steps", 2'd1, 32'd2);
        cyc(1'b1); cyc(1'b1);
        check("R5 no early irq", {31'h0, irq}, 32'h0);
        rd_chk("R5 at zero", 2'd1, 32'd0);
        cyc(1'b1);
        check("R5 irq at event reload+1", {31'h0, irq}, 32'h1);
        cyc(1'b0);
        check("R7 pulse width", {31'h0, irq}, 32'h0);
        begin
            int extra = 0;
            for (int i = 0; i < 20; i++) begin
                cyc(1'b1);
                if (irq) extra++;
            end
            check("R5 no second irq", extra, 0);
        end
        rd_chk("R5 counter stays zero", 2'd1, 32'd0);

        // R6 freeze, R2 reload on re-enable, R10, R9
        wr(2'd2, 32'h0);
        wr(2'd0, 32'd9);
        wr(2'd2, 32'h3);
        for (int i = 0; i < 4; i++) cyc(1'b1);
        rd_chk("R3 count in repeat mode", 2'd1, 32'd5);
        wr(2'd2, 32'h2);
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin
                cyc(1'b1);
                if (irq) seen++;
            end
            check("R6 no irq while off", seen, 0);
        end
        rd_chk("R6 counter frozen", 2'd1, 32'd5);
        wr(2'd2, 32'h3);
        rd_chk("R2 reload on re-enable", 2'd1, 32'd9);
        for (int i = 0; i < 3; i++) cyc(1'b1);
        wr(2'd2, 32'h3);
        rd_chk("R10 rewrite enable keeps count", 2'd1, 32'd6);
        wr(2'd2, 32'h1);
        rd_chk("R10 mode change keeps count", 2'd1, 32'd6);
        wr(2'd2, 32'h3);
        wr(2'd0, 32'd4);
        rd_chk("R9 count undisturbed", 2'd1, 32'd6);
        for (int i = 0; i < 6; i++) cyc(1'b1);
        cyc(1'b1);
        check("R4 lapse after zero", {31'h0, irq}, 32'h1);
        cyc(1'b1);
        rd_chk("R9 new reload used", 2'd1, 32'd4);
        begin
            int ev = 0;
            int at = -1;
            for (int i = 0; i < 12 && at < 0; i++) begin
                cyc(1'b1);
                ev++;
                if (irq) at = ev;
            end
            check("R4 lapse with new reload", at, first_gap(4));
        end

        // R4 / R7 random reload values and strobe densities
        for (int trial = 0; trial < 8; trial++) begin
            int p, dens, ev, last, nirq, steps;
            bit prev;
            p    = $urandom_range(0, 12);
            dens = $urandom_range(20, 100);
            if (trial == 0) begin p = 0; dens = 100; end
            wr(2'd2, 32'h0);
            wr(2'd0, p);
            wr(2'd2, 32'h3);
            rd_chk("R2 random load", 2'd1, p);
            ev = 0; last = 0; nirq = 0; steps = 0; prev = 1'b0;
            while (nirq < 4 && steps < 3000) begin
                logic t;
                t = ($urandom_range(1, 100) <= dens);
                cyc(t);
                steps++;
                if (t) ev++;
                if (irq && prev) check("R7 back-to-back irq", 1, 0);
                if (irq) begin
                    if (nirq == 0) check("R4 first interrupt", ev, first_gap(p));
                    else           check("R4 interrupt spacing", ev - last, period(p));
                    last = ev;
                    nirq++;
                end
                prev = irq;
            end
            check("R4 interrupts seen", nirq, 4);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule